// File: doc/BRIEF.md
# Configuration Status Poller

This block reads a 32-bit status register from a configurable target device through a byte-wide SPI exchange engine. A single start request begins a polling run. Each read is an eight-byte frame: a four-byte read-status command, then four reply bytes. The poller repeats the read for as long as the target reports itself busy. It gives up after a bounded number of reads.

The word from the most recent completed read is held on the outputs and decoded there. The decode gives the individual status flags, the 3-bit error code and an "operating" indication. Every run ends with exactly one single-cycle pulse. It is either a completion pulse (busy cleared) or a timeout pulse (the read limit was reached while the target was still busy). Higher-level sequencing and the bit-level shifter sit outside this block.

The controller has four states. `PS_IDLE` waits for `start`. `PS_SEND` emits the command bytes. `PS_RECV` emits filler bytes and captures the reply. `PS_EVAL` commits the word and decides what happens next. The transitions are:
- IDLE→SEND on start.
- SEND→RECV on the acknowledge of the fourth command byte.
- RECV→EVAL on the acknowledge of the fourth reply byte.
- EVAL→IDLE when busy is clear (completion).
- EVAL→IDLE when busy is set and the read limit is reached (timeout).
- EVAL→SEND when busy is set and reads remain.

Top module: `status_poller`

## Requirements
- R1: Each read frame drives, in order, the bytes 0x3C, 0x00, 0x00, 0x00, followed by four 0x00 filler bytes. `spi_req` stays high with `spi_tx_byte` stable until `spi_ack` is seen for that byte.
- R2: The four bytes received during the filler phase form the status word big-endian: the first received byte becomes bits 31:24 and the last becomes bits 7:0. Bytes received during the command phase are discarded.
- R3: The flags are decoded from the held word at these positions: busy is bit 12, done is bit 8, enable is bit 9, fail is bit 13 and device-version is bit 27.
- R4: `err_code` is bits 25:23 of the held word. The codes are 0 none, 1 ID, 2 command, 3 CRC, 4 preamble, 5 abort, 6 overflow and 7 end-of-data.
- R5: `operating` is high exactly when busy is 0, done is 1 and `err_code` is 0.
- R6: While a read returns busy=1 and reads remain, another read starts. A read that returns busy=0 ends the run with `done_pulse`.
- R7: If MAX_POLLS consecutive reads (default 128) all return busy=1, the run ends with `timeout_pulse`. Exactly MAX_POLLS reads are made.
- R8: `done_pulse` and `timeout_pulse` last a single cycle and are never high together. Each appears in the same cycle as the status word of the final read.
- R9: The read counter restarts on each accepted start, so a run that follows a timeout again allows MAX_POLLS reads.
- R10: `status_word` keeps its value between reads and while idle. It changes only when a read completes.
- R11: A `start` that arrives while a run is active is ignored and does not restart or lengthen the run.
- R12: After reset the block is idle, `spi_req` and both pulses are low, and `status_word` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a polling run (accepted when idle) |
| spi_req | output | 1 | Byte exchange request to the SPI engine |
| spi_tx_byte | output | 8 | Byte to send |
| spi_ack | input | 1 | Engine has exchanged the requested byte (one cycle) |
| spi_rx_byte | input | 8 | Byte received, valid with spi_ack |
| active | output | 1 | A run is in progress |
| status_word | output | 32 | Word from the most recent completed read |
| flag_busy | output | 1 | Busy flag of the held word |
| flag_done | output | 1 | Done flag of the held word |
| flag_enable | output | 1 | Configuration-enable flag |
| flag_fail | output | 1 | Fail flag |
| flag_devver | output | 1 | Device-version flag |
| err_code | output | 3 | Packed error code |
| operating | output | 1 | Device configured and healthy |
| done_pulse | output | 1 | Run ended with busy clear |
| timeout_pulse | output | 1 | Run ended on the read limit |

## Verification
The bench's engine model returns a scripted word for every read. The scripts cover: not busy on the first read; several busy reads before a clear word; a word with error bits and the version bit set; a fail-only word; a run that stays busy throughout; and a run whose completion lands on the very last allowed read. The distinct byte values in the reply expose byte-order mistakes. The full-length busy run separates an off-by-one read limit from a correct one, and the last-read completion separates a counter that restarts from one that carries over from the previous timeout. A start injected mid-run and a check of the held word at the start of the next run show that stray starts are ignored and that the word is kept.

// File: rtl/poll_pkg.sv
package poll_pkg;
    typedef enum logic [1:0] {
        PS_IDLE,
        PS_SEND,
        PS_RECV,
        PS_EVAL
    } poll_state_e;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned STAT_W     = 32;
    localparam int unsigned POS_BUSY   = 12;
    localparam int unsigned POS_DONE   = 8;
    localparam int unsigned POS_ENABLE = 9;
    localparam int unsigned POS_FAIL   = 13;
    localparam int unsigned POS_DEVVER = 27;
    localparam int unsigned ERR_LSB    = 23;
    localparam int unsigned ERR_W      = 3;
    localparam logic [BYTE_W-1:0] CMD_READ_STATUS = 8'h3C;
endpackage

// File: rtl/poll_fsm.sv
module poll_fsm
    import poll_pkg::*;
#(
    parameter int unsigned MAX_POLLS   = 128,
    parameter int unsigned FRAME_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              spi_ack,
    input  logic              reply_busy,
    output logic              spi_req,
    output logic [BYTE_W-1:0] spi_tx_byte,
    output logic              shift_en,
    output logic              commit,
    output logic              active,
    output logic              done_pulse,
    output logic              timeout_pulse
);
    localparam int unsigned IDX_W = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1;
    localparam int unsigned CNT_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BYTES - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_POLLS - 1);

    poll_state_e       state, state_nxt;
    logic [IDX_W-1:0]  byte_idx;
    logic [CNT_W-1:0]  poll_cnt;
    logic              last_byte, last_poll;

    assign last_byte = (byte_idx == IDX_LAST);
    assign last_poll = (poll_cnt == CNT_LAST);

    always_comb begin
        state_nxt = state;
        unique case (state)
            PS_IDLE: if (start)                  state_nxt = PS_SEND;
            PS_SEND: if (spi_ack && last_byte)   state_nxt = PS_RECV;
            PS_RECV: if (spi_ack && last_byte)   state_nxt = PS_EVAL;
            PS_EVAL: begin
                if (!reply_busy || last_poll)    state_nxt = PS_IDLE;
                else                             state_nxt = PS_SEND;
            end
            default:                             state_nxt = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_idx <= '0;
            poll_cnt <= '0;
        end else begin
            if ((state == PS_SEND || state == PS_RECV) && spi_ack)
                byte_idx <= last_byte ? '0 : byte_idx + 1'b1;
            if (state == PS_IDLE && start)
                poll_cnt <= '0;
            else if (state == PS_EVAL && reply_busy && !last_poll)
                poll_cnt <= poll_cnt + 1'b1;
        end
    end

    always_comb begin
        spi_req     = 1'b0;
        spi_tx_byte = '0;
        shift_en    = 1'b0;
        commit      = 1'b0;
        active      = (state != PS_IDLE);
        unique case (state)
            PS_IDLE: ;
            PS_SEND: begin
                spi_req     = 1'b1;
                spi_tx_byte = (byte_idx == '0) ? CMD_READ_STATUS : '0;
            end
            PS_RECV: begin
                spi_req  = 1'b1;
                shift_en = spi_ack;
            end
            PS_EVAL: commit = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_pulse    <= 1'b0;
            timeout_pulse <= 1'b0;
        end else begin
            done_pulse    <= (state == PS_EVAL) && !reply_busy;
            timeout_pulse <= (state == PS_EVAL) && reply_busy && last_poll;
        end
    end

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_pulse && timeout_pulse)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse); // R8
    AST_TIMEOUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> !timeout_pulse); // R8
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && !spi_ack && state != PS_EVAL) |=> (spi_req && $stable(spi_tx_byte))); // R1
    AST_POLL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        32'(poll_cnt) < MAX_POLLS); // R7
    AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse || timeout_pulse) |-> (state == PS_IDLE || state == PS_SEND)); // R6
endmodule

// File: rtl/reply_capture.sv
module reply_capture
    import poll_pkg::*;
#(
    parameter int unsigned WORD_W = STAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              commit,
    output logic [WORD_W-1:0] assembled,
    output logic [WORD_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assembled <= '0;
            word      <= '0;
        end else begin
            if (shift_en)
                assembled <= {assembled[WORD_W-BYTE_W-1:0], rx_byte};
            if (commit)
                word <= assembled;
        end
    end
endmodule

// File: rtl/status_decode.sv
module status_decode
    import poll_pkg::*;
(
    input  logic [STAT_W-1:0] word,
    output logic              busy,
    output logic              done,
    output logic              enable,
    output logic              fail,
    output logic              devver,
    output logic [ERR_W-1:0]  err,
    output logic              operating
);
    always_comb begin
        busy      = word[POS_BUSY];
        done      = word[POS_DONE];
        enable    = word[POS_ENABLE];
        fail      = word[POS_FAIL];
        devver    = word[POS_DEVVER];
        err       = word[ERR_LSB +: ERR_W];
        operating = !busy && done && (err == '0);
    end
endmodule

// File: rtl/status_poller.sv
module status_poller
    import poll_pkg::*;
#(
    parameter int unsigned MAX_POLLS = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        spi_req,
    output logic [7:0]  spi_tx_byte,
    input  logic        spi_ack,
    input  logic [7:0]  spi_rx_byte,
    output logic        active,
    output logic [31:0] status_word,
    output logic        flag_busy,
    output logic        flag_done,
    output logic        flag_enable,
    output logic        flag_fail,
    output logic        flag_devver,
    output logic [2:0]  err_code,
    output logic        operating,
    output logic        done_pulse,
    output logic        timeout_pulse
);
    localparam int unsigned FRAME_BYTES = STAT_W / BYTE_W;

    logic              shift_en, commit;
    logic [STAT_W-1:0] assembled;

    poll_fsm #(.MAX_POLLS(MAX_POLLS), .FRAME_BYTES(FRAME_BYTES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .spi_ack(spi_ack),
        .reply_busy(assembled[POS_BUSY]),
        .spi_req(spi_req), .spi_tx_byte(spi_tx_byte), .shift_en(shift_en),
        .commit(commit), .active(active),
        .done_pulse(done_pulse), .timeout_pulse(timeout_pulse)
    );

    reply_capture #(.WORD_W(STAT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .rx_byte(spi_rx_byte),
        .commit(commit), .assembled(assembled), .word(status_word)
    );

    status_decode u_dec (
        .word(status_word), .busy(flag_busy), .done(flag_done),
        .enable(flag_enable), .fail(flag_fail), .devver(flag_devver),
        .err(err_code), .operating(operating)
    );

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(status_word)); // R10
    AST_TIMEOUT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> flag_busy); // R7
    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> !flag_busy); // R6
    AST_OPER_HEALTHY: assert property (@(posedge clk) disable iff (!rst_n)
        operating |-> (status_word[POS_DONE] && !status_word[POS_BUSY])); // R5
endmodule

// File: tb/test_status_poller.sv
module test_status_poller;
    localparam int CLK_PERIOD = 10;
    localparam int MAXP = 128;
    localparam int LAT = 2;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic spi_req, spi_ack = 1'b0;
    logic [7:0] spi_tx_byte, spi_rx_byte = 8'h00;
    logic active, flag_busy, flag_done, flag_enable, flag_fail, flag_devver;
    logic operating, done_pulse, timeout_pulse;
    logic [31:0] status_word;
    logic [2:0] err_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    status_poller #(.MAX_POLLS(MAXP)) i_status_poller (
        .clk(clk), .rst_n(rst_n), .start(start), .spi_req(spi_req),
        .spi_tx_byte(spi_tx_byte), .spi_ack(spi_ack), .spi_rx_byte(spi_rx_byte),
        .active(active), .status_word(status_word), .flag_busy(flag_busy),
        .flag_done(flag_done), .flag_enable(flag_enable), .flag_fail(flag_fail),
        .flag_devver(flag_devver), .err_code(err_code), .operating(operating),
        .done_pulse(done_pulse), .timeout_pulse(timeout_pulse)
    );

    int checks = 0, fails = 0, results = 0;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        to;
        logic [31:0] w;
        logic [15:0] polls;
    } exp_t;
    exp_t expq[$];

    // engine model: scripted replies per read
    int n_busy = 0, frames = 0, pos = 0, lat = 0;
    logic [31:0] busy_w = 32'h0, fin_w = 32'h0;
    logic frame_bad = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            spi_ack = 1'b0; pos = 0; lat = 0;
        end else if (spi_ack) begin
            spi_ack = 1'b0;
        end else if (spi_req) begin
            if (lat < LAT) lat++;
            else begin
                logic [31:0] w;
                lat = 0;
                spi_ack = 1'b1;
                w = (frames < n_busy) ? busy_w : fin_w;
                if (pos == 0) frame_bad = (spi_tx_byte != 8'h3C);
                else if (spi_tx_byte != 8'h00) frame_bad = 1'b1;
                if (pos < 4) spi_rx_byte = 8'hFF;
                else spi_rx_byte = w[8*(7-pos) +: 8];
                if (pos == 7) begin
                    chk(!frame_bad, "R1 frame bytes", {31'd0, frame_bad}, 32'd0);
                    frames++;
                    pos = 0;
                end else pos++;
            end
        end
    end

    // monitor / scoreboard
    logic prev_pulse = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_pulse)
                chk(!done_pulse && !timeout_pulse, "R8 single-cycle pulse",
                    {30'd0, done_pulse, timeout_pulse}, 32'd0);
            if (done_pulse && timeout_pulse)
                chk(1'b0, "R8 exclusive pulses", 32'd3, 32'd1);
            prev_pulse = done_pulse || timeout_pulse;
            if ((done_pulse || timeout_pulse) && !prev_pulse_q) begin
                if (expq.size() == 0) chk(1'b0, "R6 unexpected end", 32'd1, 32'd0);
                else begin
                    exp_t e;
                    logic [31:0] w;
                    logic eop;
                    e = expq.pop_front();
                    w = e.w;
                    eop = !w[12] && w[8] && (w[25:23] == 3'd0);
                    chk(timeout_pulse == e.to, e.to ? "R7 timeout kind" : "R6 done kind",
                        {31'd0, timeout_pulse}, {31'd0, e.to});
                    chk(status_word == w, "R2 word assembly", status_word, w);
                    chk(frames == int'(e.polls), e.to ? "R7 read count" : "R6 read count",
                        frames, {16'd0, e.polls});
                    chk({flag_busy, flag_done, flag_enable, flag_fail, flag_devver} ==
                        {w[12], w[8], w[9], w[13], w[27]}, "R3 flags",
                        {27'd0, flag_busy, flag_done, flag_enable, flag_fail, flag_devver},
                        {27'd0, w[12], w[8], w[9], w[13], w[27]});
                    chk(err_code == w[25:23], "R4 error code", {29'd0, err_code}, {29'd0, w[25:23]});
                    chk(operating == eop, "R5 operating", {31'd0, operating}, {31'd0, eop});
                end
                results++;
            end
        end
    end
    logic prev_pulse_q = 1'b0;
    always @(posedge clk) prev_pulse_q <= 1'b0;

    task automatic run_job(input int nb, input logic [31:0] bw, input logic [31:0] fw, input int mid_start);
        exp_t e;
        int target;
        n_busy = nb; busy_w = bw; fin_w = fw; frames = 0;
        e.to = (nb >= MAXP);
        e.w = e.to ? bw : fw;
        e.polls = e.to ? 16'(MAXP) : 16'(nb + 1);
        expq.push_back(e);
        target = results + 1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (mid_start > 0) begin
            repeat (mid_start) @(negedge clk);
            start = 1'b1;          // R11: must be ignored
            @(negedge clk); start = 1'b0;
        end
        wait (results >= target);
        repeat (3) @(negedge clk);
        chk(!active, "R6 idle after run", {31'd0, active}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(!spi_req && !active, "R12 idle in reset", {30'd0, spi_req, active}, 32'd0);
        chk(!done_pulse && !timeout_pulse, "R12 pulses low", {30'd0, done_pulse, timeout_pulse}, 32'd0);
        chk(status_word == 32'd0, "R12 word zero", status_word, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!spi_req, "R12 no request without start", {31'd0, spi_req}, 32'd0);

        run_job(0, 32'h0, 32'h0000_0100, 0);           // R5 operating on first read
        run_job(3, 32'h0000_1000, 32'h0A5B_0300, 0);   // R2 R3 R4 byte order, err=4
        run_job(1, 32'h0000_1000, 32'h0080_0100, 0);   // R4 err=1, R5 not operating
        run_job(0, 32'h0, 32'h0000_2000, 0);           // R3 fail flag
        run_job(MAXP, 32'h0000_1100, 32'h0000_0100, 0);// R7 timeout
        run_job(MAXP-1, 32'h0000_1000, 32'h0000_0100, 0); // R9 restart, done on last read
        run_job(4, 32'h0000_1000, 32'h0000_0300, 30);  // R11 mid-run start ignored

        // R10: held word unchanged before the next read completes
        n_busy = 0; fin_w = 32'h1234_0100; frames = 0;
        expq.push_back('{to: 1'b0, w: 32'h1234_0100, polls: 16'd1});
        begin
            int target;
            target = results + 1;
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
            repeat (12) @(negedge clk);
            chk(status_word == 32'h0000_0300, "R10 word held mid-read", status_word, 32'h0000_0300);
            wait (results >= target);
            repeat (20) @(negedge clk);
            chk(status_word == 32'h1234_0100, "R10 word held while idle", status_word, 32'h1234_0100);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule